// File: doc/BRIEF.md
# IDE Channel Address Decode and Interrupt Router

This block sits beside a two-channel IDE host controller. From the controller's configuration state it works out two things. The first is whether each channel answers I/O cycles at all. The second is where each channel's command block and control block sit in I/O space. For each channel this is either the fixed compatibility address pair or a pair derived from that channel's base address registers. The selection is registered. A combinational comparator then flags every incoming I/O address that lands in an enabled channel's command block (eight bytes) or on its control byte.

The block also steers each channel's interrupt request. A channel in compatibility mode drives its own legacy interrupt line: line 14 for the primary channel and line 15 for the secondary. A channel in native mode shares the single PCI INTA output. An interrupt-pending flag follows the most recent request edge and can be cleared by a one-cycle strobe, which the surrounding logic issues when the status byte is read.

Top module: `ide_chan_router`

## Requirements
- R1: One clock after a configuration change, the primary channel (index 0) uses native bases when `native_sel[0]` and `bar_en` are both 1. Otherwise its command base is 0x1F0 and its control base is 0x3F6.
- R2: The same rule applies to the secondary channel (index 1) with `native_sel[1]`. Its compatibility bases are 0x170 and 0x376.
- R3: A native command base is the channel's `cmd_bar` with bits 2:0 cleared. A native control base is `ctl_bar` with bits 1:0 cleared, plus 2.
- R4: One clock after a change, `chan_en[0]` equals `io_space_en`, and `chan_en[1]` equals `io_space_en` AND `sec_chan_en`.
- R5: `cmd_hit[i]` is 1 in the same cycle as `io_addr` exactly when `chan_en[i]` is 1 and `io_addr` lies within base to base+7 of `cmd_base[i]`.
- R6: `ctl_hit[i]` is 1 in the same cycle exactly when `chan_en[i]` is 1 and `io_addr` equals `ctl_base[i]`. Base+1 does not hit.
- R7: One clock after a request, `irq_legacy[i]` is `chan_irq[i]` for a channel in compatibility mode and 0 for a channel in native mode. Bit 0 is interrupt line 14 and bit 1 is line 15.
- R8: One clock after a request, `irq_inta` is the OR of `chan_irq[i]` over the channels that are in native mode.
- R9: One clock after the edge, a rising edge on any `chan_irq` bit sets `irq_pend`, and a falling edge clears it. When a rise and a fall occur in the same cycle, the set wins.
- R10: `pend_clr` clears `irq_pend` one clock later, unless a request rises in that same cycle.
- R11: While `rst_n` is low, both channels are disabled, the bases hold their compatibility values, and every interrupt output and `irq_pend` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_space_en | input | 1 | I/O space enable from the command register |
| bar_en | input | 1 | Permits base-register-derived decoding |
| sec_chan_en | input | 1 | Secondary channel enable |
| native_sel | input | 2 | Per-channel native-mode select (bit 0 primary) |
| cmd_bar | input | 2x16 | Command-block base register per channel |
| ctl_bar | input | 2x16 | Control-block base register per channel |
| io_addr | input | 16 | I/O address under decode |
| chan_irq | input | 2 | Per-channel interrupt request level |
| pend_clr | input | 1 | One-cycle clear of the pending flag |
| chan_en | output | 2 | Channel decode enables |
| cmd_base | output | 2x16 | Selected command-block base per channel |
| ctl_base | output | 2x16 | Selected control-block base per channel |
| cmd_hit | output | 2 | Address falls in a command block |
| ctl_hit | output | 2 | Address equals a control byte |
| irq_legacy | output | 2 | Legacy interrupt lines 14 and 15 |
| irq_inta | output | 1 | Shared PCI INTA |
| irq_pend | output | 1 | Interrupt-pending flag |

## Verification
Enables, bases, interrupt outputs and the pending flag are registered, so each is due exactly one clock after the inputs that produce it. The address hits are combinational from the registered bases and the address held at that moment. The driver applies one stimulus set on each falling edge and queues the expected values for it. The monitor pops one item shortly after the next rising edge, while the address is still held, so every comparison falls in the one cycle the result is due.

// File: rtl/ide_rt_pkg.sv
// Package: shared constants for the IDE channel router.
// Assumes exactly two channels, since the compatibility addresses exist only for two.
package ide_rt_pkg;
    localparam int NUM_CH     = 2;
    localparam int DEF_ADDR_W = 16;

    // Compatibility command-block base for a channel index.
    function automatic logic [15:0] compat_cmd(input int ch);
        return (ch == 0) ? 16'h01F0 : 16'h0170;
    endfunction

    // Compatibility control-block byte for a channel index.
    function automatic logic [15:0] compat_ctl(input int ch);
        return (ch == 0) ? 16'h03F6 : 16'h0376;
    endfunction
endpackage

// File: rtl/ide_base_sel.sv
// Module: per-channel base selection.
// Registers the channel enable and picks the compatibility or native command
// and control bases. Assumes the caller has already combined the native
// qualifiers and the channel gate.
module ide_base_sel
    import ide_rt_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int CH_IDX    = 0,
    parameter int CMD_ALIGN = 3,
    parameter int CTL_ALIGN = 2,
    parameter int CTL_OFS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              native,
    input  logic              chan_on,
    input  logic [ADDR_W-1:0] cmd_bar,
    input  logic [ADDR_W-1:0] ctl_bar,
    output logic              en_q,
    output logic [ADDR_W-1:0] cmd_base_q,
    output logic [ADDR_W-1:0] ctl_base_q
);
    localparam logic [ADDR_W-1:0] CMD_MASK  = ~ADDR_W'((1 << CMD_ALIGN) - 1);
    localparam logic [ADDR_W-1:0] CTL_MASK  = ~ADDR_W'((1 << CTL_ALIGN) - 1);
    localparam logic [ADDR_W-1:0] CMD_LEG   = ADDR_W'(compat_cmd(CH_IDX));
    localparam logic [ADDR_W-1:0] CTL_LEG   = ADDR_W'(compat_ctl(CH_IDX));
    localparam logic [ADDR_W-1:0] CTL_DELTA = ADDR_W'(CTL_OFS);

    logic [ADDR_W-1:0] cmd_nat, ctl_nat, cmd_nxt, ctl_nxt;

    // Derive the native bases from the base registers.
    always_comb begin
        cmd_nat = cmd_bar & CMD_MASK;
        ctl_nat = (ctl_bar & CTL_MASK) + CTL_DELTA;
    end

    // Choose between the native and compatibility address pairs.
    always_comb begin
        cmd_nxt = native ? cmd_nat : CMD_LEG;
        ctl_nxt = native ? ctl_nat : CTL_LEG;
    end

    // Hold the selected bases and the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            cmd_base_q <= CMD_LEG;
            ctl_base_q <= CTL_LEG;
        end else begin
            en_q       <= chan_on;
            cmd_base_q <= cmd_nxt;
            ctl_base_q <= ctl_nxt;
        end
    end
endmodule

// File: rtl/ide_io_hit.sv
// Module: per-channel address comparator.
// Combinational. Flags a command-block hit over 2**SPAN_W bytes and a
// control-byte hit on one address. Assumes cmd_base is aligned to the span.
module ide_io_hit #(
    parameter int ADDR_W = 16,
    parameter int SPAN_W = 3
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [ADDR_W-1:0] ctl_base,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_hit,
    output logic              ctl_hit
);
    localparam logic [ADDR_W-1:0] SPAN_MASK = ~ADDR_W'((1 << SPAN_W) - 1);

    // Compare the address against both blocks of an enabled channel.
    always_comb begin
        cmd_hit = en && ((addr & SPAN_MASK) == (cmd_base & SPAN_MASK));
        ctl_hit = en && (addr == ctl_base);
    end
endmodule

// File: rtl/ide_irq_route.sv
// Module: interrupt steering and pending flag.
// Sends each channel's request to its legacy line or to the shared INTA, and
// keeps a pending flag that follows request edges. Assumes level requests.
module ide_irq_route #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] native,
    input  logic [NCH-1:0] req,
    input  logic           pend_clr,
    output logic [NCH-1:0] legacy_q,
    output logic           inta_q,
    output logic           pend_q
);
    logic [NCH-1:0] req_prev;
    logic [NCH-1:0] rise, fall;
    logic           pend_nxt;

    // Detect request edges against the previous cycle.
    always_comb begin
        rise = req & ~req_prev;
        fall = ~req & req_prev;
    end

    // Next pending value: a set wins over a fall or a clear.
    always_comb begin
        if (|rise)                   pend_nxt = 1'b1;
        else if ((|fall) || pend_clr) pend_nxt = 1'b0;
        else                          pend_nxt = pend_q;
    end

    // Register the steered interrupt outputs and the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_prev <= '0;
            legacy_q <= '0;
            inta_q   <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            req_prev <= req;
            legacy_q <= req & ~native;
            inta_q   <= |(req & native);
            pend_q   <= pend_nxt;
        end
    end
endmodule

// File: rtl/ide_chan_router.sv
// Module: top of the IDE channel decode and interrupt router.
// Qualifies native mode and channel gating, instantiates one base selector and
// one comparator per channel, and the shared interrupt router.
module ide_chan_router
    import ide_rt_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int CMD_ALIGN = 3,
    parameter int CTL_ALIGN = 2,
    parameter int CTL_OFS   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          io_space_en,
    input  logic                          bar_en,
    input  logic                          sec_chan_en,
    input  logic [NUM_CH-1:0]             native_sel,
    input  logic [NUM_CH-1:0][ADDR_W-1:0] cmd_bar,
    input  logic [NUM_CH-1:0][ADDR_W-1:0] ctl_bar,
    input  logic [ADDR_W-1:0]             io_addr,
    input  logic [NUM_CH-1:0]             chan_irq,
    input  logic                          pend_clr,
    output logic [NUM_CH-1:0]             chan_en,
    output logic [NUM_CH-1:0][ADDR_W-1:0] cmd_base,
    output logic [NUM_CH-1:0][ADDR_W-1:0] ctl_base,
    output logic [NUM_CH-1:0]             cmd_hit,
    output logic [NUM_CH-1:0]             ctl_hit,
    output logic [NUM_CH-1:0]             irq_legacy,
    output logic                          irq_inta,
    output logic                          irq_pend
);
    logic [NUM_CH-1:0] native;
    logic [NUM_CH-1:0] chan_on;

    // Native decoding needs both the channel select and the global permit.
    always_comb native = native_sel & {NUM_CH{bar_en}};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        if (g == 0) begin : g_pri
            // Primary channel follows the I/O space enable alone.
            always_comb chan_on[g] = io_space_en;
        end else begin : g_sec
            // Secondary channel also needs its own enable.
            always_comb chan_on[g] = io_space_en & sec_chan_en;
        end

        ide_base_sel #(
            .ADDR_W(ADDR_W), .CH_IDX(g), .CMD_ALIGN(CMD_ALIGN),
            .CTL_ALIGN(CTL_ALIGN), .CTL_OFS(CTL_OFS)
        ) u_sel (
            .clk(clk), .rst_n(rst_n), .native(native[g]), .chan_on(chan_on[g]),
            .cmd_bar(cmd_bar[g]), .ctl_bar(ctl_bar[g]),
            .en_q(chan_en[g]), .cmd_base_q(cmd_base[g]), .ctl_base_q(ctl_base[g])
        );

        ide_io_hit #(.ADDR_W(ADDR_W), .SPAN_W(CMD_ALIGN)) u_hit (
            .en(chan_en[g]), .cmd_base(cmd_base[g]), .ctl_base(ctl_base[g]),
            .addr(io_addr), .cmd_hit(cmd_hit[g]), .ctl_hit(ctl_hit[g])
        );
    end

    ide_irq_route #(.NCH(NUM_CH)) u_irq (
        .clk(clk), .rst_n(rst_n), .native(native), .req(chan_irq),
        .pend_clr(pend_clr), .legacy_q(irq_legacy), .inta_q(irq_inta),
        .pend_q(irq_pend)
    );
endmodule

// File: rtl/ide_chan_router_chk.sv
// Checker: temporal properties of ide_chan_router, bound to the top below.
module ide_chan_router_chk
    import ide_rt_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   io_space_en,
    input logic                   bar_en,
    input logic                   sec_chan_en,
    input logic [1:0]             native_sel,
    input logic [1:0][15:0]       cmd_bar,
    input logic [15:0]            io_addr,
    input logic [1:0]             chan_irq,
    input logic                   pend_clr,
    input logic [1:0]             chan_en,
    input logic [1:0][15:0]       cmd_base,
    input logic [1:0][15:0]       ctl_base,
    input logic [1:0]             cmd_hit,
    input logic [1:0]             ctl_hit,
    input logic [1:0]             irq_legacy,
    input logic                   irq_inta,
    input logic                   irq_pend
);
    logic       past_ok;
    logic [1:0] irq_seen;
    logic [1:0] rise_c;

    // Track whether one cycle out of reset has passed, and the last request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok  <= 1'b0;
            irq_seen <= '0;
        end else begin
            past_ok  <= 1'b1;
            irq_seen <= chan_irq;
        end
    end

    // Rising request edges as seen by the checker.
    always_comb rise_c = chan_irq & ~irq_seen;

    a_r1_pri_compat: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !($past(native_sel[0]) && $past(bar_en)) |->
            cmd_base[0] == 16'h01F0 && ctl_base[0] == 16'h03F6);

    a_r2_sec_compat: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !($past(native_sel[1]) && $past(bar_en)) |->
            cmd_base[1] == 16'h0170 && ctl_base[1] == 16'h0376);

    a_r3_base_align: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_base[0][2:0] == 3'b000 && cmd_base[1][2:0] == 3'b000 &&
        ctl_base[0][1:0] == 2'b10 && ctl_base[1][1:0] == 2'b10);

    a_r3_pri_native: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(native_sel[0]) && $past(bar_en) |->
            cmd_base[0] == ($past(cmd_bar[0]) & 16'hFFF8));

    a_r4_sec_gate: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !($past(io_space_en) && $past(sec_chan_en)) |-> !chan_en[1]);

    a_r5_cmd_window: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_hit[0] |-> chan_en[0] && io_addr[15:3] == cmd_base[0][15:3]);

    a_r6_ctl_exact: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_hit[1] |-> chan_en[1] && io_addr == ctl_base[1]);

    a_r7_legacy_src: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && irq_legacy[0] |-> $past(chan_irq[0]));

    a_r8_inta_src: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && irq_inta |-> $past(|chan_irq));

    a_r9_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        |rise_c |=> irq_pend);

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        pend_clr && !(|rise_c) |=> !irq_pend);
endmodule

bind ide_chan_router ide_chan_router_chk u_chk (
    .clk(clk), .rst_n(rst_n), .io_space_en(io_space_en), .bar_en(bar_en),
    .sec_chan_en(sec_chan_en), .native_sel(native_sel), .cmd_bar(cmd_bar),
    .io_addr(io_addr), .chan_irq(chan_irq), .pend_clr(pend_clr),
    .chan_en(chan_en), .cmd_base(cmd_base), .ctl_base(ctl_base),
    .cmd_hit(cmd_hit), .ctl_hit(ctl_hit), .irq_legacy(irq_legacy),
    .irq_inta(irq_inta), .irq_pend(irq_pend)
);

// File: tb/ide_chan_router_bench.sv
module ide_chan_router_bench;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             io_space_en = 1'b0, bar_en = 1'b0, sec_chan_en = 1'b0;
    logic [1:0]       native_sel = '0;
    logic [1:0][15:0] cmd_bar = '0, ctl_bar = '0;
    logic [15:0]      io_addr = '0;
    logic [1:0]       chan_irq = '0;
    logic             pend_clr = 1'b0;
    logic [1:0]       chan_en, cmd_hit, ctl_hit, irq_legacy;
    logic [1:0][15:0] cmd_base, ctl_base;
    logic             irq_inta, irq_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    ide_chan_router u_ide_chan_router (
        .clk(clk), .rst_n(rst_n), .io_space_en(io_space_en), .bar_en(bar_en),
        .sec_chan_en(sec_chan_en), .native_sel(native_sel), .cmd_bar(cmd_bar),
        .ctl_bar(ctl_bar), .io_addr(io_addr), .chan_irq(chan_irq),
        .pend_clr(pend_clr), .chan_en(chan_en), .cmd_base(cmd_base),
        .ctl_base(ctl_base), .cmd_hit(cmd_hit), .ctl_hit(ctl_hit),
        .irq_legacy(irq_legacy), .irq_inta(irq_inta), .irq_pend(irq_pend)
    );

    typedef struct {
        string            tag;
        logic [1:0]       en, ch, kh, lg;
        logic [1:0][15:0] cb, kb;
        logic             ia, pd;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0, errors = 0;
    logic [1:0]  m_prev = '0;
    logic        m_pend = 1'b0;
    logic        done = 1'b0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one stimulus set and queue the values due one clock later.
    task automatic drive(input logic io, input logic be, input logic se,
                         input logic [1:0] ns, input logic [1:0] irq,
                         input logic clr, input logic [15:0] addr,
                         input string tag);
        exp_t e;
        logic [1:0] nat, rise, fall;
        @(negedge clk);
        io_space_en = io; bar_en = be; sec_chan_en = se; native_sel = ns;
        chan_irq = irq; pend_clr = clr; io_addr = addr;
        nat   = ns & {2{be}};
        e.tag = tag;
        e.en  = {io & se, io};
        e.cb[0] = nat[0] ? (cmd_bar[0] & 16'hFFF8) : 16'h01F0;
        e.kb[0] = nat[0] ? ((ctl_bar[0] & 16'hFFFC) + 16'd2) : 16'h03F6;
        e.cb[1] = nat[1] ? (cmd_bar[1] & 16'hFFF8) : 16'h0170;
        e.kb[1] = nat[1] ? ((ctl_bar[1] & 16'hFFFC) + 16'd2) : 16'h0376;
        for (int i = 0; i < 2; i++) begin
            e.ch[i] = e.en[i] && ((addr & 16'hFFF8) == e.cb[i]);
            e.kh[i] = e.en[i] && (addr == e.kb[i]);
        end
        e.lg = irq & ~nat;
        e.ia = |(irq & nat);
        rise = irq & ~m_prev;
        fall = ~irq & m_prev;
        if (|rise)             m_pend = 1'b1;
        else if (|fall || clr) m_pend = 1'b0;
        m_prev = irq;
        e.pd = m_pend;
        sb_q.push_back(e);
    endtask

    // Monitor: after each rising edge, compare the oldest queued item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.tag, "chan_en", 32'(chan_en), 32'(e.en));
                chk(e.tag, "cmd_base", 32'(cmd_base), 32'(e.cb));
                chk(e.tag, "ctl_base", 32'(ctl_base), 32'(e.kb));
                chk(e.tag, "cmd_hit", 32'(cmd_hit), 32'(e.ch));
                chk(e.tag, "ctl_hit", 32'(ctl_hit), 32'(e.kh));
                chk(e.tag, "irq_legacy", 32'(irq_legacy), 32'(e.lg));
                chk(e.tag, "irq_inta", 32'(irq_inta), 32'(e.ia));
                chk(e.tag, "irq_pend", 32'(irq_pend), 32'(e.pd));
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R11: reset state with active-looking inputs.
        io_space_en = 1'b1; sec_chan_en = 1'b1; bar_en = 1'b1; native_sel = 2'b11;
        cmd_bar[0] = 16'hC00F; ctl_bar[0] = 16'hC017;
        cmd_bar[1] = 16'hD0A3; ctl_bar[1] = 16'hD0B1;
        chan_irq = 2'b11; io_addr = 16'hC008;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", "chan_en", 32'(chan_en), 32'd0);
        chk("R11", "cmd_base", 32'(cmd_base), {16'h0170, 16'h01F0});
        chk("R11", "ctl_base", 32'(ctl_base), {16'h0376, 16'h03F6});
        chk("R11", "irq_legacy", 32'(irq_legacy), 32'd0);
        chk("R11", "irq_inta", 32'(irq_inta), 32'd0);
        chk("R11", "irq_pend", 32'(irq_pend), 32'd0);
        chk("R11", "hits", 32'({cmd_hit, ctl_hit}), 32'd0);
        chan_irq = 2'b00; pend_clr = 1'b0; native_sel = 2'b00; bar_en = 1'b0;
        rst_n = 1'b1;

        //    io   bar  sec  nsel   irq    clr  addr
        drive(1'b0, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 16'h01F0, "R4 io off");
        drive(1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 16'h01F0, "R1 R5 pri base");
        drive(1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 16'h01F7, "R5 top of block");
        drive(1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 16'h01F8, "R5 above block");
        drive(1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 16'h01EF, "R5 below block");
        drive(1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 16'h03F6, "R6 pri ctl");
        drive(1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 16'h03F7, "R6 ctl plus one");
        drive(1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 16'h0170, "R4 sec gated");
        drive(1'b1, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 16'h0174, "R2 R4 sec on");
        drive(1'b1, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 16'h0376, "R2 R6 sec ctl");
        drive(1'b1, 1'b0, 1'b1, 2'b01, 2'b00, 1'b0, 16'h01F0, "R1 native no permit");
        drive(1'b1, 1'b1, 1'b1, 2'b01, 2'b00, 1'b0, 16'hC00F, "R1 R3 pri native");
        drive(1'b1, 1'b1, 1'b1, 2'b01, 2'b00, 1'b0, 16'hC016, "R3 R6 pri native ctl");
        drive(1'b1, 1'b1, 1'b1, 2'b10, 2'b00, 1'b0, 16'hD0B2, "R2 R3 sec native");
        drive(1'b1, 1'b1, 1'b1, 2'b10, 2'b00, 1'b0, 16'hD0A7, "R3 R5 sec native cmd");
        drive(1'b1, 1'b0, 1'b1, 2'b00, 2'b01, 1'b0, 16'h0000, "R7 R9 pri legacy irq");
        drive(1'b1, 1'b0, 1'b1, 2'b00, 2'b11, 1'b0, 16'h0000, "R7 both legacy");
        drive(1'b1, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 16'h0000, "R9 fall clears");
        drive(1'b1, 1'b1, 1'b1, 2'b11, 2'b10, 1'b0, 16'h0000, "R8 sec native inta");
        drive(1'b1, 1'b1, 1'b1, 2'b11, 2'b01, 1'b0, 16'h0000, "R8 R9 rise beats fall");
        drive(1'b1, 1'b1, 1'b1, 2'b11, 2'b01, 1'b1, 16'h0000, "R10 clear held");
        drive(1'b1, 1'b1, 1'b1, 2'b11, 2'b11, 1'b1, 16'h0000, "R10 rise beats clear");
        drive(1'b1, 1'b1, 1'b1, 2'b01, 2'b11, 1'b0, 16'h0000, "R7 R8 mixed modes");
        drive(1'b1, 1'b1, 1'b0, 2'b01, 2'b00, 1'b0, 16'h0000, "R9 both fall");

        while (sb_q.size() != 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule